// File: doc/BRIEF.md
# Root Port Legacy Interrupt Queue

This block collects legacy INTx assert and deassert events for a PCIe root port. Each event carries a lane number (0 to 3) and a level. The block packs every accepted event into a word and stores it in a small circular queue. Software drains the queue through a 32-bit register port. Reads of the register port are combinational on the address and take effect in the same cycle. Writes take effect at the next rising clock edge.

A decode register records that an INTx event has arrived. A mask register gates that record onto a single level-sensitive interrupt output. A root port control register holds a bridge-enable bit, which drives an output. The same register reports whether the queue holds entries and whether an event was lost. A PHY status register shows the state of a link-up input.

Software reads the head of the queue from either of two read words. Writing any value to either read word removes the head entry.

Top module: `intx_queue_ctrl`

## Requirements
- R1: After reset the decode, mask and bridge-enable registers read 0, the overflow flag reads 0, the queue is empty, and both `irq` and `bridge_en` are 0.
- R2: The mask register (offset 0x13C) stores all 32 written bits. In the decode register (offset 0x138), bit 16 is set one cycle after an event is accepted into the queue.
- R3: `irq` is 1 exactly when some decode bit and the same mask bit are both 1. It follows a queued event, a mask write or a decode write on the cycle after that write or event.
- R4: Writing the decode register clears each bit written as 1. If the queue still holds entries after this clear, bit 16 reads 1 again. The same rule applies on a mask write.
- R5: The head read word 1 (offset 0x158) has this layout: bit 31 = 1 (valid), bit 29 = event level, bits 28:27 = lane, and all other bits 0. Read word 2 (offset 0x15C) reads 0.
- R6: The queue holds at most DEPTH-1 events. An event that arrives while the queue is full is dropped and sets sticky bit 19 of the root port control register (offset 0x148). Writing 1 to that bit clears it. If a drop and a clear happen in the same cycle, the drop wins.
- R7: Reading either read word returns the head entry and does not remove it. Both read words return 0 when the queue is empty.
- R8: A write of any value to offset 0x158 or 0x15C removes one entry. Such a write has no effect while the queue is empty.
- R9: Bit 0 of the root port control register is read/write and drives `bridge_en`. Bit 18 of the same register reads 1 while the queue holds entries.
- R10: Bit 11 of the PHY status register (offset 0x144) equals the `link_up` input. All other bits of that register read 0.
- R11: Events leave the queue in arrival order, including after the pointers wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| evt_valid | input | 1 | One INTx event is offered this cycle |
| evt_lane | input | 2 | Lane of the offered event |
| evt_level | input | 1 | 1 = assert, 0 = deassert |
| link_up | input | 1 | Link state, shown in the PHY status register |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt output |
| bridge_en | output | 1 | Bridge enable |

## Verification
The bench builds the block with its default parameters: a 16-entry queue and 12-bit register offsets. With these values the queue fills after fifteen events, so a dropped event and the overflow flag are reached within a few dozen cycles. Draining the full queue after earlier traffic moves both pointers past the last slot, which exercises ordering across the wrap. Checks on removal from an empty queue and on the decode bit re-arming while entries remain then need only a handful of register operations each.

// File: rtl/intq_pkg.sv
`timescale 1ns/1ps
package intq_pkg;
  // register byte offsets
  localparam int unsigned OFF_DECODE = 32'h138;
  localparam int unsigned OFF_MASK   = 32'h13C;
  localparam int unsigned OFF_PHY    = 32'h144;
  localparam int unsigned OFF_RPCTL  = 32'h148;
  localparam int unsigned OFF_HEAD1  = 32'h158;
  localparam int unsigned OFF_HEAD2  = 32'h15C;

  // bit positions
  localparam int unsigned B_INTX   = 16;
  localparam int unsigned B_LINK   = 11;
  localparam int unsigned B_BREN   = 0;
  localparam int unsigned B_NEMPTY = 18;
  localparam int unsigned B_OVF    = 19;
  localparam int unsigned W_LANE   = 27;
  localparam int unsigned W_LEVEL  = 29;
  localparam int unsigned W_VALID  = 31;

  typedef struct packed {
    logic       level;
    logic [1:0] lane;
  } intq_evt_t;

  localparam int unsigned EVT_W = $bits(intq_evt_t);

  function automatic logic [31:0] pack_head(input intq_evt_t e);
    logic [31:0] w;
    w = '0;
    w[W_VALID]          = 1'b1;
    w[W_LEVEL]          = e.level;
    w[W_LANE +: 2]      = e.lane;
    return w;
  endfunction
endpackage

// File: rtl/intq_rst_sync.sv
`timescale 1ns/1ps
module intq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/intq_fifo.sv
`timescale 1ns/1ps
module intq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic          push_ok
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W-1:0] wr_nxt, rd_nxt;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_nxt  = bump(wr_q);
    rd_nxt  = bump(rd_q);
    empty   = (wr_q == rd_q);
    full    = (wr_nxt == rd_q);
    push_ok = push & ~full;
    pop_ok  = pop & ~empty;
    head    = mem[rd_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_nxt;
      if (pop_ok)  rd_q <= rd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end
endmodule

// File: rtl/intq_ctrl_regs.sv
`timescale 1ns/1ps
module intq_ctrl_regs
  import intq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_decode,
  input  logic        wr_mask,
  input  logic        wr_rpctl,
  input  logic [31:0] wdata,
  input  logic        push_ok,
  input  logic        drop,
  input  logic        q_empty,
  output logic        intx_q,
  output logic [31:0] mask_q,
  output logic        bren_q,
  output logic        ovf_q,
  output logic        irq
);
  logic        intx_d, bren_d, ovf_d;
  logic [31:0] mask_d;

  always_comb begin
    intx_d = intx_q;
    mask_d = mask_q;
    bren_d = bren_q;
    ovf_d  = ovf_q;
    if (wr_decode) intx_d = (intx_q & ~wdata[B_INTX]) | ~q_empty;
    if (wr_mask) begin
      mask_d = wdata;
      if (!q_empty) intx_d = 1'b1;
    end
    if (push_ok) intx_d = 1'b1;
    if (wr_rpctl) begin
      bren_d = wdata[B_BREN];
      if (wdata[B_OVF]) ovf_d = 1'b0;
    end
    if (drop) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intx_q <= 1'b0;
      mask_q <= '0;
      bren_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      intx_q <= intx_d;
      ovf_q  <= ovf_d;
      if (wr_mask)  mask_q <= mask_d;
      if (wr_rpctl) bren_q <= bren_d;
    end
  end

  assign irq = intx_q & mask_q[B_INTX];
endmodule

// File: rtl/intq_rdmux.sv
`timescale 1ns/1ps
module intq_rdmux
  import intq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              intx,
  input  logic [31:0]       mask,
  input  logic              link_up,
  input  logic              bren,
  input  logic              ovf,
  input  logic              q_empty,
  input  intq_evt_t         head,
  output logic [31:0]       rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_DECODE)) begin
      rdata[B_INTX] = intx;
    end else if (addr == ADDR_W'(OFF_MASK)) begin
      rdata = mask;
    end else if (addr == ADDR_W'(OFF_PHY)) begin
      rdata[B_LINK] = link_up;
    end else if (addr == ADDR_W'(OFF_RPCTL)) begin
      rdata[B_BREN]   = bren;
      rdata[B_NEMPTY] = ~q_empty;
      rdata[B_OVF]    = ovf;
    end else if (addr == ADDR_W'(OFF_HEAD1)) begin
      if (!q_empty) rdata = pack_head(head);
    end
  end
endmodule

// File: rtl/intx_queue_ctrl.sv
`timescale 1ns/1ps
module intx_queue_ctrl
  import intq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [1:0]        evt_lane,
  input  logic              evt_level,
  input  logic              link_up,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              bridge_en
);
  logic      rst_sync_n;
  logic      wr_decode, wr_mask, wr_rpctl, pop_req;
  logic      q_empty, q_full, push_ok, drop;
  logic      intx_q, bren_q, ovf_q;
  logic [31:0] mask_q;
  intq_evt_t evt_in, head;

  intq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    wr_decode = reg_wr & (reg_addr == ADDR_W'(OFF_DECODE));
    wr_mask   = reg_wr & (reg_addr == ADDR_W'(OFF_MASK));
    wr_rpctl  = reg_wr & (reg_addr == ADDR_W'(OFF_RPCTL));
    pop_req   = reg_wr & ((reg_addr == ADDR_W'(OFF_HEAD1)) |
                          (reg_addr == ADDR_W'(OFF_HEAD2)));
    evt_in.level = evt_level;
    evt_in.lane  = evt_lane;
    drop = evt_valid & q_full;
  end

  intq_fifo #(.DEPTH(DEPTH), .DW(EVT_W)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n),
    .push(evt_valid), .din(evt_in), .pop(pop_req),
    .head(head), .empty(q_empty), .full(q_full), .push_ok(push_ok)
  );

  intq_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_decode(wr_decode), .wr_mask(wr_mask), .wr_rpctl(wr_rpctl),
    .wdata(reg_wdata), .push_ok(push_ok), .drop(drop), .q_empty(q_empty),
    .intx_q(intx_q), .mask_q(mask_q), .bren_q(bren_q), .ovf_q(ovf_q),
    .irq(irq)
  );

  intq_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr(reg_addr), .intx(intx_q), .mask(mask_q), .link_up(link_up),
    .bren(bren_q), .ovf(ovf_q), .q_empty(q_empty), .head(head),
    .rdata(reg_rdata)
  );

  assign bridge_en = bren_q;
endmodule

// File: rtl/intq_chk.sv
`timescale 1ns/1ps
module intq_chk
  import intq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              q_full,
  input logic              q_empty,
  input logic              ovf,
  input logic              intx,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic              bridge_en
);
  logic wr_any_fifo;
  assign wr_any_fifo = reg_wr & ((reg_addr == ADDR_W'(OFF_HEAD1)) |
                                 (reg_addr == ADDR_W'(OFF_HEAD2)));

  p_push_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !q_full && !reg_wr && reg_addr == ADDR_W'(OFF_MASK) && reg_rdata[B_INTX]) |=> irq);

  p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_DECODE) && !q_empty) |=> intx);

  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && q_full) |=> ovf);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_wr && reg_addr == ADDR_W'(OFF_RPCTL) && reg_wdata[B_OVF])) |=> ovf);

  p_empty_head_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && (reg_addr == ADDR_W'(OFF_HEAD1) || reg_addr == ADDR_W'(OFF_HEAD2))) |-> reg_rdata == 32'h0);

  p_pop_empty_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !evt_valid && wr_any_fifo) |=> q_empty);

  p_bren_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_RPCTL)) |=> bridge_en == $past(reg_wdata[B_BREN]));
endmodule

bind intx_queue_ctrl intq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .evt_valid(evt_valid),
  .q_full(q_full), .q_empty(q_empty), .ovf(ovf_q), .intx(intx_q),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq(irq), .bridge_en(bridge_en)
);

// File: tb/tb_intx_queue_ctrl.sv
`timescale 1ns/1ps
module tb_intx_queue_ctrl;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 12;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;
  localparam logic [11:0] A_DEC = 12'h138, A_MSK = 12'h13C, A_PHY = 12'h144,
                          A_RPC = 12'h148, A_H1 = 12'h158, A_H2 = 12'h15C;
  localparam int NV = 20;
  // {op, requirement number, address, data, expected}
  localparam logic [81:0] VEC [NV] = '{
    {OP_RD, 4'd10, A_PHY, 32'h0,        32'h0000_0800}, // R10
    {OP_RD, 4'd1,  A_DEC, 32'h0,        32'h0},         // R1
    {OP_WR, 4'd2,  A_MSK, 32'h0001_0000, 32'h0},
    {OP_RD, 4'd2,  A_MSK, 32'h0,        32'h0001_0000}, // R2
    {OP_EV, 4'd5,  12'h0, 32'h6,        32'h0},         // lane 2 assert
    {OP_RD, 4'd5,  A_H1,  32'h0,        32'hB000_0000}, // R5
    {OP_RD, 4'd5,  A_H2,  32'h0,        32'h0},         // R5
    {OP_RD, 4'd7,  A_H1,  32'h0,        32'hB000_0000}, // R7 no pop
    {OP_RD, 4'd2,  A_DEC, 32'h0,        32'h0001_0000}, // R2
    {OP_RD, 4'd9,  A_RPC, 32'h0,        32'h0004_0000}, // R9
    {OP_EV, 4'd11, 12'h0, 32'h1,        32'h0},         // lane 1 deassert
    {OP_WR, 4'd8,  A_H2,  32'hDEAD_BEEF, 32'h0},
    {OP_RD, 4'd11, A_H1,  32'h0,        32'h8800_0000}, // R11 / R8
    {OP_WR, 4'd4,  A_DEC, 32'h0001_0000, 32'h0},
    {OP_RD, 4'd4,  A_DEC, 32'h0,        32'h0001_0000}, // R4 re-armed
    {OP_WR, 4'd8,  A_H1,  32'h0,        32'h0},
    {OP_RD, 4'd7,  A_H1,  32'h0,        32'h0},         // R7 empty
    {OP_WR, 4'd4,  A_DEC, 32'h0001_0000, 32'h0},
    {OP_RD, 4'd4,  A_DEC, 32'h0,        32'h0},         // R4 cleared
    {OP_WR, 4'd9,  A_RPC, 32'h1,        32'h0}
  };

  logic clk, rst_n, evt_valid, evt_level, link_up, reg_wr, irq, bridge_en;
  logic [1:0] evt_lane;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, rv;
  int checks, failures;

  intx_queue_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_lane(evt_lane),
    .evt_level(evt_level), .link_up(link_up), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .bridge_en(bridge_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ev(input logic [1:0] lane, input logic lvl);
    @(negedge clk);
    evt_valid = 1'b1; evt_lane = lane; evt_level = lvl;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] word1(input logic [1:0] lane, input logic lvl);
    return 32'h8000_0000 | (32'(lvl) << 29) | (32'(lane) << 27);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 bridge_en", 32'(bridge_en), 32'h0);
    rd(A_DEC, rv); chk("R1 decode", rv, 32'h0);
    rd(A_MSK, rv); chk("R1 mask", rv, 32'h0);
    rd(A_RPC, rv); chk("R1 rpctl", rv, 32'h0);
    rd(A_H1, rv);  chk("R1 head", rv, 32'h0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; evt_valid = 1'b0; evt_lane = '0; evt_level = 1'b0;
    link_up = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [11:0] a;
      logic [31:0] d, e;
      {op, rq, a, d, e} = VEC[i];
      case (op)
        OP_WR: wr(a, d);
        OP_EV: ev(d[1:0], d[2]);
        default: begin
          rd(a, rv);
          checks++;
          if (rv !== e) begin
            failures++;
            $display("FAIL R%0d vector %0d actual=%h expected=%h", rq, i, rv, e);
          end
        end
      endcase
    end
    chk("R9 bridge_en out", 32'(bridge_en), 32'h1);
    link_up = 1'b0;
    rd(A_PHY, rv); chk("R10 link down", rv, 32'h0);

    // interrupt gating
    chk("R3 idle irq", 32'(irq), 32'h0);
    ev(2'd0, 1'b1);
    chk("R3 irq after event", 32'(irq), 32'h1);
    wr(A_MSK, 32'h0);
    chk("R3 irq masked", 32'(irq), 32'h0);
    wr(A_MSK, 32'h0001_0000);
    chk("R3 irq unmasked", 32'(irq), 32'h1);
    wr(A_H1, 32'h0);
    chk("R4 decode holds after pop", 32'(irq), 32'h1);
    wr(A_DEC, 32'h0001_0000);
    chk("R4 irq after clear", 32'(irq), 32'h0);

    // fill past capacity, then drain in order across the wrap
    for (int i = 0; i < DEPTH; i++) ev(2'(i % 4), i[0]);
    rd(A_RPC, rv); chk("R6 full with overflow", rv, 32'h000C_0001);
    for (int i = 0; i < DEPTH - 1; i++) begin
      rd(A_H1, rv); chk("R11 order", rv, word1(2'(i % 4), i[0]));
      wr(A_H2, 32'h0);
    end
    rd(A_H1, rv);  chk("R6 dropped event absent", rv, 32'h0);
    rd(A_RPC, rv); chk("R6 overflow sticky", rv, 32'h0008_0001);
    wr(A_RPC, 32'h0008_0001);
    rd(A_RPC, rv); chk("R6 overflow cleared", rv, 32'h0000_0001);

    // pop on empty must not move the read pointer
    wr(A_H1, 32'h0);
    ev(2'd2, 1'b0);
    rd(A_H1, rv); chk("R8 empty pop ignored", rv, 32'h9000_0000);
    rd(A_RPC, rv); chk("R8 one entry", rv, 32'h0004_0001);

    // reset in the middle of activity
    wr(A_MSK, 32'hFFFF_FFFF);
    rd(A_MSK, rv); chk("R2 mask all bits", rv, 32'hFFFF_FFFF);
    do_reset();
    check_reset_state();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule